// File: doc/BRIEF.md
# Companded PCM Byte Expander

This block turns one received 8-bit companded telephony sample into a signed linear value. A select input picks one of the two standard companding laws, either µ-law or A-law. The decoded value is placed in a common two's-complement word that is one bit wider than the usual 16-bit linear format. That extra low-order bit keeps half-step values exact.

A robbed-bit compatibility option exists for µ-law traffic whose lowest bit is borrowed for signaling. When it is on, the block never looks at the received low bit. It decodes the byte as if that bit were worth half its usual step, so the output lands midway between the two codes the byte could have been. The worst error is therefore half a step. With A-law selected the option has no effect, and the signaling bit gets no other treatment.

Each byte comes with a one-cycle strobe. The result is registered and appears one clock later with its own one-cycle valid pulse.

Top module: `pcm_expander`

## Requirements
- R1: With `law_sel`=0 (µ-law), the byte is complemented. Bit 7 of the complemented byte is the sign, bits 6:4 are the segment s and bits 3:0 the mantissa m. The magnitude is (((2m+33) << s) − 33) × 8. Examples: 0xFE → 16, 0xF0 → 240, 0x80 → 64248.
- R2: With `law_sel`=1 (A-law), the byte is XORed with 0x55 before decoding. Segment s is bits 6:4 and mantissa m is bits 3:0 of the result. The magnitude is (2m+1)×16 for s=0 and ((2m+33) << (s−1))×16 otherwise. Examples: 0xD5 → 16, 0xC5 → 528, 0xAA → 64512.
- R3: Sign. For µ-law, a complemented bit 7 of 1 gives a negative output (0x00 → −64248). For A-law, bit 7 of 1 after the XOR gives a positive output (0x55 → −16, 0x2A → −64512).
- R4: Both µ-law zero codes, 0xFF and 0x7F, give exactly 0.
- R5: In µ-law with `rob_en`=1, the value of the received bit 0 has no effect on the output (0xFE and 0xFF both → 8; 0x80 and 0x81 both → 63224).
- R6: In µ-law with `rob_en`=1, the mantissa term 2m is replaced by 4·(m>>1)+1. The output is then the midpoint of the two normal decodes (0x80 → 63224, between 64248 and 62200).
- R7: With A-law selected, `rob_en` has no effect (0xD5 → 16 and 0xD4 → 48 either way).
- R8: `out_valid` pulses for exactly one cycle, on the clock edge after each edge where `in_valid` is high. `out_sample` carries that byte's result in the same cycle.
- R9: While `in_valid` is low, `out_valid` is low and `out_sample` holds its last value.
- R10: During and after reset, `out_valid`=0 and `out_sample`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: `in_code` holds a byte to decode |
| in_code | input | 8 | Received companded byte |
| law_sel | input | 1 | 0 = µ-law, 1 = A-law |
| rob_en | input | 1 | Robbed-bit compatibility (µ-law only) |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_sample | output | OUT_W (17) | Signed linear sample, scaled by 2 relative to 16-bit linear |

## Verification
The bench drives the extreme codes of both laws. Dropping the complement or the 0x55 mask would turn 0xFF, 0xD5 and 0xAA into large or wrongly signed values. It checks the two µ-law zero codes, which a wrong bias would make nonzero. It also checks the A-law first segment, where a missing special case doubles the value. For robbed-bit mode it decodes byte pairs that differ only in bit 0 and compares them with the midpoint. A design that still read the low bit, or that forced it to 0 or 1 instead of half weight, misses by half a step. Finally it sends the same A-law bytes with the option on and off, and it checks that the output holds between strobes.

// File: rtl/g711x_pkg.sv
package g711x_pkg;
   localparam int CODE_W = 8;
   localparam int MAG_W  = 16;
   localparam int BASE_W = MAG_W + 1;

   typedef enum logic {
      LAW_MU = 1'b0,
      LAW_A  = 1'b1
   } law_e;

   typedef struct packed {
      logic             neg;
      logic [MAG_W-1:0] mag;
   } smag_t;
endpackage

// File: rtl/g711x_mu_dec.sv
module g711x_mu_dec
   import g711x_pkg::*;
#(
   parameter bit ROB_SUPPORT = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   input  logic              rob,
   output smag_t             res
);
   localparam logic [5:0] BIAS = 6'd33;

   logic [CODE_W-1:0] inv;
   logic [4:0]        twice_man;
   logic [5:0]        biased;
   logic [12:0]       shifted;
   logic [12:0]       mag14;

   assign inv = ~code;

   generate
      if (ROB_SUPPORT) begin : g_rob
         // half-weight substitute for the discarded low bit
         assign twice_man = rob ? {inv[3:1], 2'b01} : {inv[3:0], 1'b0};
      end else begin : g_norob
         logic unused_rob;
         assign unused_rob = rob;
         assign twice_man  = {inv[3:0], 1'b0};
      end
   endgenerate

   assign biased  = {1'b0, twice_man} + BIAS;
   assign shifted = {7'd0, biased} << inv[6:4];
   assign mag14   = shifted - {7'd0, BIAS};

   assign res.neg = inv[7];
   assign res.mag = {mag14, 3'b000};
endmodule

// File: rtl/g711x_a_dec.sv
module g711x_a_dec
   import g711x_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   output smag_t             res
);
   localparam logic [CODE_W-1:0] EVEN_MASK = 8'h55;

   logic [CODE_W-1:0] x;
   logic [2:0]        seg;
   logic [2:0]        amt;
   logic [5:0]        lin;
   logic [11:0]       mag13;

   assign x   = code ^ EVEN_MASK;
   assign seg = x[6:4];
   assign amt = (seg == 3'd0) ? 3'd0 : seg - 3'd1;
   assign lin = {(seg != 3'd0), x[3:0], 1'b1};
   assign mag13 = {6'd0, lin} << amt;

   assign res.neg = ~x[7];
   assign res.mag = {mag13, 4'b0000};
endmodule

// File: rtl/g711x_signer.sv
module g711x_signer
   import g711x_pkg::*;
#(
   parameter int OUT_W = 17
) (
   input  smag_t             in_val,
   output logic [OUT_W-1:0]  out_val
);
   localparam int PAD = OUT_W - BASE_W;

   logic [BASE_W-1:0] pos;
   logic [BASE_W-1:0] twos;

   assign pos  = {1'b0, in_val.mag};
   assign twos = in_val.neg ? (~pos + 1'b1) : pos;

   generate
      if (PAD == 0) begin : g_exact
         assign out_val = twos;
      end else begin : g_pad
         assign out_val = {twos, {PAD{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/pcm_expander.sv
module pcm_expander
   import g711x_pkg::*;
#(
   parameter int OUT_W       = 17,
   parameter bit ROB_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_code,
   input  logic             law_sel,
   input  logic             rob_en,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_sample
);
   generate
      if (OUT_W < BASE_W) begin : g_bad_width
         $error("pcm_expander: OUT_W must be at least %0d", BASE_W);
      end
   endgenerate

   smag_t            mu_res;
   smag_t            a_res;
   smag_t            pick;
   logic [OUT_W-1:0] lin_next;
   logic             rob_mu;

   // robbed-bit option only reaches the µ-law path
   assign rob_mu = rob_en & (law_e'(law_sel) == LAW_MU);

   g711x_mu_dec #(.ROB_SUPPORT(ROB_SUPPORT)) u_mu (
      .code (in_code),
      .rob  (rob_mu),
      .res  (mu_res)
   );

   g711x_a_dec u_a (
      .code (in_code),
      .res  (a_res)
   );

   assign pick = (law_e'(law_sel) == LAW_A) ? a_res : mu_res;

   g711x_signer #(.OUT_W(OUT_W)) u_sign (
      .in_val  (pick),
      .out_val (lin_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sample <= lin_next;
         end
      end
   end
endmodule

// File: rtl/g711x_chk.sv
module g711x_chk #(
   parameter int OUT_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [7:0]       in_code,
   input logic             law_sel,
   input logic             rob_en,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_sample
);
   localparam int LSB_OFS = OUT_W - 17;

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R9

   AST_HOLD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_sample)); // R9

   AST_ROB_HALF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rob_en && !law_sel) |=> out_sample[LSB_OFS+3]); // R6

   AST_A_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && law_sel) |=> (out_sample != '0)); // R2

   AST_A_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && law_sel && (in_code[7] == 1'b1)) |=> !out_sample[OUT_W-1]); // R3

   AST_MU_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !law_sel && !in_code[7]) |=>
         (out_sample[OUT_W-1] || out_sample == '0)); // R3

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_sample == '0)); // R10
endmodule

bind pcm_expander g711x_chk #(.OUT_W(OUT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_code    (in_code),
   .law_sel    (law_sel),
   .rob_en     (rob_en),
   .out_valid  (out_valid),
   .out_sample (out_sample)
);

// File: tb/pcm_expander_test.sv
module pcm_expander_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_code = 8'h00;
   logic        law_sel = 1'b0;
   logic        rob_en = 1'b0;
   logic        out_valid;
   logic [16:0] out_sample;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pcm_expander uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_code    (in_code),
      .law_sel    (law_sel),
      .rob_en     (rob_en),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one byte, then check the result one edge later
   task automatic decode(input string req, input logic [7:0] code,
                         input logic law, input logic rob, input int exp);
      @(negedge clk);
      in_code  = code;
      law_sel  = law;
      rob_en   = rob;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " R8 valid"}, int'(out_valid), 1);
      check(req, $signed(out_sample), exp);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R10 valid", int'(out_valid), 0);
      check("R10 sample", $signed(out_sample), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after", $signed(out_sample), 0);
   endtask

   task automatic t_mulaw();
      decode("R1 0xFE", 8'hFE, 1'b0, 1'b0, 16);
      decode("R1 0xF0", 8'hF0, 1'b0, 1'b0, 240);
      decode("R1 0x80", 8'h80, 1'b0, 1'b0, 64248);
      decode("R1 0x81", 8'h81, 1'b0, 1'b0, 62200);
      decode("R3 mu 0x00", 8'h00, 1'b0, 1'b0, -64248);
      decode("R4 0xFF", 8'hFF, 1'b0, 1'b0, 0);
      decode("R4 0x7F", 8'h7F, 1'b0, 1'b0, 0);
   endtask

   task automatic t_alaw();
      decode("R2 0xD5", 8'hD5, 1'b1, 1'b0, 16);
      decode("R2 0xC5", 8'hC5, 1'b1, 1'b0, 528);
      decode("R2 0xAA", 8'hAA, 1'b1, 1'b0, 64512);
      decode("R2 0xD4", 8'hD4, 1'b1, 1'b0, 48);
      decode("R3 A 0x55", 8'h55, 1'b1, 1'b0, -16);
      decode("R3 A 0x2A", 8'h2A, 1'b1, 1'b0, -64512);
   endtask

   task automatic t_robbed();
      decode("R5 0xFE", 8'hFE, 1'b0, 1'b1, 8);
      decode("R5 0xFF", 8'hFF, 1'b0, 1'b1, 8);
      decode("R6 0x80", 8'h80, 1'b0, 1'b1, 63224);
      decode("R5 0x81", 8'h81, 1'b0, 1'b1, 63224);
      decode("R6 0x01", 8'h01, 1'b0, 1'b1, -63224);
   endtask

   task automatic t_rob_alaw();
      decode("R7 0xD5", 8'hD5, 1'b1, 1'b1, 16);
      decode("R7 0xD4", 8'hD4, 1'b1, 1'b1, 48);
      decode("R7 0xAA", 8'hAA, 1'b1, 1'b1, 64512);
   endtask

   task automatic t_hold();
      decode("R9 load", 8'hF0, 1'b0, 1'b0, 240);
      in_code = 8'h00;
      law_sel = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R9 valid low", int'(out_valid), 0);
         check("R9 held", $signed(out_sample), 240);
      end
   endtask

   initial begin
      t_reset();
      t_mulaw();
      t_alaw();
      t_robbed();
      t_rob_alaw();
      t_hold();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule